// File: doc/BRIEF.md
# Pre-Trigger Delay Sequencer with Conversion Locks

This block turns one start pulse per PWM period into a set of timed pre-trigger pulses for an ADC conversion sequencer. A rising edge on `trig_in` restarts a 16-bit delay counter from zero. Each pre-trigger channel has its own active delay. The channel emits a one-cycle pulse on `pretrig[i]` when the counter reaches that delay, so the order of the conversions follows the order of the delays. The counter runs on the same clock as the PWM, which lets delays be written in PWM ticks. A typical setup uses delay 0 for the current sample at the start of the period. The voltage sample uses a delay that software recomputes each period from the duty cycle and keeps at 180 ticks or more, which leaves room for a roughly 1.25 µs conversion.

A fired channel holds a lock until its conversion-complete input `conv_done[i]` returns. While any lock is held, the single converter is busy. A channel that becomes due during that time does not fire, and the sticky flag `seq_err` is raised. Software can use this flag as an interrupt request and clears it by writing 1 to `seq_err_clr`. The delays are double-buffered. Writes land in buffer registers, and the buffers move into the active set only at the first `trig_in` rising edge after software has set the load-OK flag. That flag then clears by itself.

The design is organised around three small state machines. The counter machine has two states. It moves from CNT_IDLE to CNT_RUN on a trigger rise, restarts within CNT_RUN on a further rise, and returns to CNT_IDLE when the count saturates at all ones. Each channel has a lock machine that moves from LK_FREE to LK_BUSY when the channel fires and back to LK_FREE on its `conv_done`. The reload machine moves from LD_IDLE to LD_ARMED on `ldok_set` and back to LD_IDLE when the transfer happens at a trigger rise.

Top module: `pretrig_seq`

## Requirements
- R1: After reset, `pretrig`, `lock`, `seq_err` and `ldok` are all 0, and every active delay is 0.
- R2: A rising edge of `trig_in` restarts the count at 0. A channel with active delay d pulses `pretrig[i]` for exactly one cycle, visible d+1 cycles after the clock edge that sampled the rise. Holding `trig_in` high does not restart the count again.
- R3: Each channel fires at most once per period. A new rising edge while the count is running starts a fresh period and re-arms every channel.
- R4: `lock[i]` rises in the same cycle as the `pretrig[i]` pulse and stays high until `conv_done[i]` is sampled high. `conv_done` of another channel, or `conv_done` on a free channel, has no effect.
- R5: A channel that becomes due while any lock is held emits no pulse and sets `seq_err`. The channel does not retry later in that period.
- R6: When several channels become due in the same cycle, the lowest index fires. The others count as collisions and set `seq_err`.
- R7: `seq_err` stays set until `seq_err_clr` is sampled high. A collision in the same cycle as the clear wins, and the flag stays set.
- R8: A write selects a channel by index with `dly_wr_sel` (0 = first channel) and goes to that channel's buffer. The buffer does not change the active delay until a trigger rise happens while `ldok` is set.
- R9: `ldok_set` sets `ldok`. `ldok` holds its value with no trigger and clears at the trigger rise that transfers the buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the PWM time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | PWM period-start trigger; its rising edge starts a period |
| dly_wr_en | input | 1 | Write strobe for a delay buffer |
| dly_wr_sel | input | IDX_W | Channel index of the buffer written |
| dly_wr_val | input | CNT_W | Delay value written to the buffer |
| ldok_set | input | 1 | Arms the buffered delays for transfer |
| ldok | output | 1 | Load-OK flag, pending transfer |
| conv_done | input | N_CH | Conversion-complete per channel |
| pretrig | output | N_CH | One-cycle pre-trigger pulses |
| lock | output | N_CH | Per-channel lock, conversion outstanding |
| seq_err | output | 1 | Sticky sequence-error flag |
| seq_err_clr | input | 1 | Write-1 clear of `seq_err` |

## Verification
Each internal fault shows up at the ports within one trigger period. If the counter restarts at the wrong point, every `pretrig` pulse lands on the wrong cycle. If a lock releases early or late, the error flag changes state, or the second pulse appears or disappears, for a delay gap exactly at the boundary (lock length plus one cycle). If a buffer transfers early or is lost, the pulses still follow the old delays in the period after the write, and `ldok` fails to clear at the first trigger rise.

// File: rtl/pdly_pkg.sv
package pdly_pkg;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef enum logic {
        LK_FREE = 1'b0,
        LK_BUSY = 1'b1
    } lock_state_e;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_ARMED = 1'b1
    } ld_state_e;

endpackage

// File: rtl/pdly_counter.sv
module pdly_counter
    import pdly_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    output logic             trig_rise,
    output logic             running,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_state_e       st_q, st_d;
    logic             trig_q;
    logic [CNT_W-1:0] cnt_q;

    assign trig_rise = trig_in & ~trig_q;
    assign running   = (st_q == CNT_RUN);
    assign cnt       = cnt_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_IDLE: if (trig_rise) st_d = CNT_RUN;
            CNT_RUN: begin
                if (trig_rise)              st_d = CNT_RUN;
                else if (cnt_q == CNT_MAX)  st_d = CNT_IDLE;
            end
            default: st_d = CNT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CNT_IDLE;
        else        st_q <= st_d;
    end

    // datapath: edge detector and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            trig_q <= trig_in;
            if (trig_rise)
                cnt_q <= '0;
            else if (st_q == CNT_RUN && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: a rise always starts a fresh count at zero
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> (running && cnt == '0));

    // R2: a held-high trigger is not a second rise
    p_level_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && $past(trig_in)) |-> !trig_rise);

endmodule

// File: rtl/pdly_dlyreg.sv
module pdly_dlyreg
    import pdly_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CH  = 2,
    parameter int IDX_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_sel,
    input  logic [CNT_W-1:0]           wr_val,
    input  logic                       ldok_set,
    input  logic                       trig_rise,
    output logic                       ldok,
    output logic [N_CH-1:0][CNT_W-1:0] dly_act
);

    ld_state_e ld_q, ld_d;
    logic      transfer;

    assign transfer = trig_rise && (ld_q == LD_ARMED);
    assign ldok     = (ld_q == LD_ARMED);

    always_comb begin
        ld_d = ld_q;
        unique case (ld_q)
            LD_IDLE:  if (ldok_set) ld_d = LD_ARMED;
            LD_ARMED: if (trig_rise && !ldok_set) ld_d = LD_IDLE;
            default:  ld_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= LD_IDLE;
        else        ld_q <= ld_d;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_slot
        logic [CNT_W-1:0] buf_q;
        logic [CNT_W-1:0] act_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_q <= '0;
                act_q <= '0;
            end else begin
                if (wr_en && wr_sel == IDX_W'(g))
                    buf_q <= wr_val;
                if (transfer)
                    act_q <= buf_q;
            end
        end

        assign dly_act[g] = act_q;
    end

    // R9: the transfer consumes the load-OK flag
    p_ldok_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ldok && trig_rise && !ldok_set) |=> !ldok);

    // R9: without a trigger the flag holds
    p_ldok_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ldok && !trig_rise) |=> ldok);

    // R8: active delays move only on a transfer
    p_act_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_rise && ldok) |=> $stable(dly_act));

endmodule

// File: rtl/pdly_chan.sv
module pdly_chan
    import pdly_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_rise,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] dly,
    input  logic             fire,
    input  logic             conv_done,
    output logic             due,
    output logic             pretrig,
    output logic             lock
);

    lock_state_e lk_q, lk_d;
    logic        fired_q;
    logic        pulse_q;

    assign due     = running && (cnt == dly) && !fired_q;
    assign lock    = (lk_q == LK_BUSY);
    assign pretrig = pulse_q;

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_FREE: if (fire)      lk_d = LK_BUSY;
            LK_BUSY: if (conv_done) lk_d = LK_FREE;
            default: lk_d = LK_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_FREE;
        else        lk_q <= lk_d;
    end

    // once-per-period marker and registered pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
            if (trig_rise)
                fired_q <= 1'b0;
            else if (due)
                fired_q <= 1'b1;
        end
    end

    // R4: lock comes up together with the pulse
    p_lock_with_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pretrig && lock));

    // R4: lock only drops on its own completion
    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !conv_done) |=> lock);

    // R2: pulse is a single cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pretrig |=> !pretrig);

endmodule

// File: rtl/pretrig_seq.sv
module pretrig_seq #(
    parameter  int CNT_W = 16,
    parameter  int N_CH  = 2,
    localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             dly_wr_en,
    input  logic [IDX_W-1:0] dly_wr_sel,
    input  logic [CNT_W-1:0] dly_wr_val,
    input  logic             ldok_set,
    output logic             ldok,
    input  logic [N_CH-1:0]  conv_done,
    output logic [N_CH-1:0]  pretrig,
    output logic [N_CH-1:0]  lock,
    output logic             seq_err,
    input  logic             seq_err_clr
);

    logic                       trig_rise;
    logic                       running;
    logic [CNT_W-1:0]           cnt;
    logic [N_CH-1:0][CNT_W-1:0] dly_act;
    logic [N_CH-1:0]            due;
    logic [N_CH-1:0]            fire;
    logic                       any_lock;
    logic                       collide;
    logic                       err_q;

    pdly_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_rise (trig_rise),
        .running   (running),
        .cnt       (cnt)
    );

    pdly_dlyreg #(.CNT_W(CNT_W), .N_CH(N_CH), .IDX_W(IDX_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dly_wr_en),
        .wr_sel    (dly_wr_sel),
        .wr_val    (dly_wr_val),
        .ldok_set  (ldok_set),
        .trig_rise (trig_rise),
        .ldok      (ldok),
        .dly_act   (dly_act)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pdly_chan #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_rise (trig_rise),
            .running   (running),
            .cnt       (cnt),
            .dly       (dly_act[c]),
            .fire      (fire[c]),
            .conv_done (conv_done[c]),
            .due       (due[c]),
            .pretrig   (pretrig[c]),
            .lock      (lock[c])
        );
    end

    assign any_lock = |lock;

    // grant: converter free, lowest due index wins
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            fire[i] = due[i] && !any_lock && !seen;
            seen    = seen | due[i];
        end
    end

    assign collide = |(due & ~fire);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           err_q <= 1'b0;
        else if (collide)     err_q <= 1'b1;
        else if (seq_err_clr) err_q <= 1'b0;
    end

    assign seq_err = err_q;

    // R6: at most one pre-trigger per cycle
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pretrig));

    // R5: nothing fires while a conversion is outstanding
    p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_lock |=> (pretrig == '0));

    // R5: a due channel meeting a lock raises the error
    p_err_on_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|due && any_lock) |=> seq_err);

    // R7: the flag is sticky without a clear
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !seq_err_clr) |=> seq_err);

endmodule

// File: tb/tb_pretrig_seq.sv
module tb_pretrig_seq;

    localparam int CNT_W = 16;
    localparam int N_CH  = 2;
    localparam int NV    = 8;
    localparam int VEC [NV][3] = '{
        '{0, 180, 40}, '{0, 20, 40}, '{0, 41, 40}, '{0, 42, 40},
        '{50, 10, 5},  '{30, 30, 3}, '{5, 6, 1},   '{100, 3, 2}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             trig_in;
    logic             dly_wr_en;
    logic [0:0]       dly_wr_sel;
    logic [CNT_W-1:0] dly_wr_val;
    logic             ldok_set;
    logic             ldok;
    logic [N_CH-1:0]  conv_done;
    logic [N_CH-1:0]  pretrig;
    logic [N_CH-1:0]  lock;
    logic             seq_err;
    logic             seq_err_clr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int f_cnt  [2];
    int f_time [2];
    bit lk_at  [2];
    bit stray_lock0;

    always #10 clk = ~clk;

    pretrig_seq #(.CNT_W(CNT_W), .N_CH(N_CH)) dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .dly_wr_en(dly_wr_en), .dly_wr_sel(dly_wr_sel), .dly_wr_val(dly_wr_val),
        .ldok_set(ldok_set), .ldok(ldok), .conv_done(conv_done),
        .pretrig(pretrig), .lock(lock), .seq_err(seq_err), .seq_err_clr(seq_err_clr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_dly(input int ch, input int v);
        @(negedge clk);
        dly_wr_en  = 1'b1;
        dly_wr_sel = 1'(ch);
        dly_wr_val = CNT_W'(v);
        @(negedge clk);
        dly_wr_en  = 1'b0;
    endtask

    task automatic arm_load();
        @(negedge clk) ldok_set = 1'b1;
        @(negedge clk) ldok_set = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk) seq_err_clr = 1'b1;
        @(negedge clk) seq_err_clr = 1'b0;
    endtask

    // sample t=0 is the first negedge after the edge that sees the rise
    task automatic run_period(input int lat, input int hold, input int retrig_t,
                              input int clr_t, input int stray_t, input int len);
        int pend [2];
        pend = '{0, 0};
        f_cnt = '{0, 0};
        f_time = '{-1, -1};
        lk_at = '{1'b0, 1'b0};
        stray_lock0 = 1'b0;
        @(negedge clk) trig_in = 1'b1;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            if (t >= hold - 1) trig_in = 1'b0;
            if (t == retrig_t) trig_in = 1'b1;
            conv_done   = '0;
            seq_err_clr = (t == clr_t);
            for (int i = 0; i < 2; i++) begin
                if (pend[i] > 0) begin
                    pend[i]--;
                    if (pend[i] == 0) conv_done[i] = 1'b1;
                end
            end
            if (t == stray_t) conv_done[1] = 1'b1;
            if (t == stray_t + 2) stray_lock0 = lock[0];
            for (int i = 0; i < 2; i++) begin
                if (pretrig[i]) begin
                    f_cnt[i]++;
                    f_time[i] = t;
                    lk_at[i]  = lock[i];
                    pend[i]   = lat;
                end
            end
        end
        trig_in     = 1'b0;
        conv_done   = '0;
        seq_err_clr = 1'b0;
    endtask

    // expected pulse samples from the lock and priority rules
    function automatic void model(input int d0, input int d1, input int lat,
                                  output int e0, output int e1, output bit eerr);
        if (d0 == d1) begin
            e0 = d0 + 1; e1 = -1; eerr = 1'b1;
        end else if (d0 < d1) begin
            e0 = d0 + 1;
            if (d1 <= d0 + 1 + lat) begin e1 = -1; eerr = 1'b1; end
            else begin e1 = d1 + 1; eerr = 1'b0; end
        end else begin
            e1 = d1 + 1;
            if (d0 <= d1 + 1 + lat) begin e0 = -1; eerr = 1'b1; end
            else begin e0 = d0 + 1; eerr = 1'b0; end
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int e0, e1;
        bit eerr;
        rst_n = 1'b0; trig_in = 1'b0; dly_wr_en = 1'b0; dly_wr_sel = '0;
        dly_wr_val = '0; ldok_set = 1'b0; conv_done = '0; seq_err_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pretrig == '0, "R1 pretrig", int'(pretrig), 0);
        check(lock == '0,    "R1 lock",    int'(lock),    0);
        check(seq_err == 0,  "R1 seq_err", int'(seq_err), 0);
        check(ldok == 0,     "R1 ldok",    int'(ldok),    0);

        // table walk: R2 timing, R4 lock, R5/R6 collisions
        for (int v = 0; v < NV; v++) begin
            write_dly(0, VEC[v][0]);
            write_dly(1, VEC[v][1]);
            arm_load();
            clear_err();
            run_period(VEC[v][2], 1, -1, -1, -1,
                       ((VEC[v][0] > VEC[v][1]) ? VEC[v][0] : VEC[v][1]) + VEC[v][2] + 8);
            model(VEC[v][0], VEC[v][1], VEC[v][2], e0, e1, eerr);
            check(f_time[0] == e0, "R2/R5 ch0 time", f_time[0], e0);
            check(f_time[1] == e1, "R2/R5 ch1 time", f_time[1], e1);
            check(f_cnt[0] == ((e0 >= 0) ? 1 : 0), "R3 ch0 count", f_cnt[0], (e0 >= 0) ? 1 : 0);
            check(f_cnt[1] == ((e1 >= 0) ? 1 : 0), "R3 ch1 count", f_cnt[1], (e1 >= 0) ? 1 : 0);
            check(seq_err == eerr, "R5/R6 seq_err", int'(seq_err), int'(eerr));
            if (e0 >= 0) check(lk_at[0], "R4 lock0 with pulse", int'(lk_at[0]), 1);
            if (e1 >= 0) check(lk_at[1], "R4 lock1 with pulse", int'(lk_at[1]), 1);
            check(lock == '0, "R4 locks released", int'(lock), 0);
        end

        // R8: buffered writes wait for load-OK (active now 100,3)
        write_dly(0, 10);
        write_dly(1, 200);
        clear_err();
        run_period(2, 1, -1, -1, -1, 120);
        check(f_time[0] == 101, "R8 old ch0 delay kept", f_time[0], 101);
        check(f_time[1] == 4,   "R8 old ch1 delay kept", f_time[1], 4);
        arm_load();
        repeat (5) @(negedge clk);
        check(ldok == 1, "R9 ldok holds without trigger", int'(ldok), 1);
        run_period(2, 1, -1, -1, -1, 210);
        check(ldok == 0, "R9 ldok cleared by transfer", int'(ldok), 0);
        check(f_time[0] == 11,  "R8 new ch0 delay", f_time[0], 11);
        check(f_time[1] == 201, "R8 new ch1 delay", f_time[1], 201);

        // R2: trigger held high for four cycles starts one period only
        run_period(3, 4, -1, -1, -1, 30);
        check(f_cnt[0] == 1,   "R2 held trigger count", f_cnt[0], 1);
        check(f_time[0] == 11, "R2 held trigger time", f_time[0], 11);

        // R3: rise mid-period restarts and re-arms
        run_period(3, 1, 50, -1, -1, 270);
        check(f_cnt[0] == 2,    "R3 ch0 re-armed", f_cnt[0], 2);
        check(f_time[0] == 62,  "R3 ch0 restart time", f_time[0], 62);
        check(f_cnt[1] == 1,    "R3 ch1 once", f_cnt[1], 1);
        check(f_time[1] == 252, "R3 ch1 restart time", f_time[1], 252);

        // R4: completions on free or foreign channels are ignored
        @(negedge clk) conv_done = 2'b11;
        @(negedge clk) conv_done = 2'b00;
        check(lock == '0, "R4 idle completion", int'(lock), 0);
        run_period(40, 1, -1, -1, 20, 260);
        check(stray_lock0 == 1, "R4 foreign completion", int'(stray_lock0), 1);
        check(f_time[1] == 201, "R4 period after stray", f_time[1], 201);

        // R7: sticky flag, write-1 clear, collision wins over clear
        write_dly(0, 30);
        write_dly(1, 30);
        arm_load();
        clear_err();
        run_period(3, 1, -1, -1, -1, 40);
        repeat (10) @(negedge clk);
        check(seq_err == 1, "R7 sticky", int'(seq_err), 1);
        clear_err();
        check(seq_err == 0, "R7 cleared", int'(seq_err), 0);
        run_period(3, 1, -1, 30, -1, 40);
        check(seq_err == 1, "R7 set beats clear", int'(seq_err), 1);
        run_period(3, 1, -1, 35, -1, 40);
        check(seq_err == 0, "R7 later clear", int'(seq_err), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule